// File: doc/BRIEF.md
# Fault-Recovery Rescheduling Sequencer

This block controls fault recovery in a multi-issue execute stage. Each cycle it decides which instruction sources the downstream scheduler works through, and in what order. There are three sources. The first is a shadow copy of the bundle that has just executed. The second is a shadow copy of decoded instructions that were left unscheduled in the previous cycle. The third is the freshly decoded bundle. The block also decides when fetch and decode must be frozen.

When a sensor reports a new fault, the just-executed bundle is squashed. The sequencer then puts its shadow copy first in the schedule. If the squashed instructions are recent enough, the shadow copy is merged with the next decoded bundle and no stall is needed. Otherwise the front end is stalled. Replay cycles repeat while any descriptor in the executed shadow is still pending.

When no fault is new, leftovers go first and the decoded bundle second. A one-cycle stall is inserted only when leftovers remain pending or a decoded instruction depends on the next bundle. The stall output is registered. The scheduler and the switch datapath are outside this block.

Top module: `recov_seq_ctrl`

## Requirements
- R1: After reset the stall output is low, the sequencer is in normal mode, and with idle inputs it plans leftover shadow (code 2) first, decoded bundle (code 3) second, with the shadow select at 0.
- R2: A new fault with the late-source flag low plans executed shadow (code 1) first and decoded bundle (code 3) second, drives the shadow select to 1 (executed shadow), and leaves the stall low in the next cycle.
- R3: A new fault with the late-source flag high plans executed shadow (code 1) first and nothing (code 0) second, drives the select to 1, and raises the stall in the next cycle.
- R4: In replay mode with no new fault, while any executed-shadow pending bit is set, the plan stays executed shadow then nothing, the select stays 1, and the stall stays high in the next cycle.
- R5: In replay mode with no new fault and no executed-shadow pending bit, the sequencer returns to normal mode in that same cycle. It plans leftover shadow then decoded bundle with the select at 0, and the next stall follows R7.
- R6: In normal mode with no new fault, the plan is leftover shadow (code 2) first and decoded bundle (code 3) second, with the select at 0.
- R7: In normal mode with no new fault, the stall is high in the next cycle exactly when any leftover pending bit or any decoded dependency bit is set, so a single such cycle produces a one-cycle stall.
- R8: The executed-shadow capture enable is high every cycle. The leftover-shadow capture enable is high exactly when the stall output is low.
- R9: A new fault arriving during replay takes priority over the replay and is handled as in R2 or R3 according to its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| new_fault_i | input | 1 | A fault not present last cycle was detected in execute |
| old_src_i | input | 1 | Squashed instructions came from an older decode (1) or the recent one (0) |
| xsh_pend_i | input | ISSUES | Pending bit per descriptor of the executed-bundle shadow |
| lsh_pend_i | input | ISSUES | Pending bit per descriptor of the leftover shadow |
| dec_dep_i | input | ISSUES | Dependency-on-next-bundle bit per decoded instruction |
| src_sel_o | output | 1 | Shadow feeding the switch: 1 executed shadow, 0 leftover shadow |
| pass0_src_o | output | 2 | First scheduler pass source: 0 none, 1 executed, 2 leftover, 3 decoded |
| pass1_src_o | output | 2 | Second scheduler pass source, same code |
| cap_left_o | output | 1 | Capture decoded bundle into leftover shadow |
| cap_exec_o | output | 1 | Capture execute-entry bundle into executed shadow |
| stall_o | output | 1 | Registered fetch/decode stall |

## Verification
The bench builds the block with four issues and the looped any-bit reduction. With that setup, a single set bit in any lane position can be shown to drive a replay or a stall decision. The scenarios cover merge recovery and stalled replay. They include replay that continues across cycles and then ends, faults that pre-empt a replay, and one-cycle stalls caused separately by leftovers and by dependencies. Each expected plan and stall value is queued per cycle and compared against the ports.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXEC = 2'd1,
      SRC_LEFT = 2'd2,
      SRC_DEC  = 2'd3
   } src_e;

   typedef enum logic {
      ST_RUN    = 1'b0,
      ST_REPLAY = 1'b1
   } mode_e;

   typedef struct packed {
      src_e  first;
      src_e  second;
      logic  sel_exec;
      logic  stall_nxt;
      mode_e mode_nxt;
   } plan_t;

endpackage

// File: rtl/rsc_any.sv
module rsc_any #(
   parameter int WIDTH = 4,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             any_o
);
   generate
      if (STYLE == 0) begin : g_flat
         assign any_o = |vec_i;
      end else begin : g_chain
         logic [WIDTH:0] chain;
         assign chain[0] = 1'b0;
         for (genvar g = 0; g < WIDTH; g++) begin : g_lane
            assign chain[g+1] = chain[g] | vec_i[g];
         end
         assign any_o = chain[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/rsc_plan.sv
module rsc_plan
   import rsc_pkg::*;
(
   input  mode_e mode_i,
   input  logic  fault_i,
   input  logic  old_src_i,
   input  logic  x_any_i,
   input  logic  l_any_i,
   input  logic  d_any_i,
   output plan_t plan_o
);
   always_comb begin
      plan_o = '{first: SRC_LEFT, second: SRC_DEC, sel_exec: 1'b0,
                 stall_nxt: 1'b0, mode_nxt: ST_RUN};
      if (fault_i) begin
         plan_o.first    = SRC_EXEC;
         plan_o.sel_exec = 1'b1;
         if (old_src_i) begin
            plan_o.second    = SRC_NONE;
            plan_o.stall_nxt = 1'b1;
            plan_o.mode_nxt  = ST_REPLAY;
         end else begin
            plan_o.second    = SRC_DEC;
         end
      end else if (mode_i == ST_REPLAY && x_any_i) begin
         plan_o.first     = SRC_EXEC;
         plan_o.second    = SRC_NONE;
         plan_o.sel_exec  = 1'b1;
         plan_o.stall_nxt = 1'b1;
         plan_o.mode_nxt  = ST_REPLAY;
      end else begin
         plan_o.stall_nxt = l_any_i | d_any_i;
      end
   end
endmodule

// File: rtl/rsc_state.sv
module rsc_state
   import rsc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  plan_t plan_i,
   output mode_e mode_o,
   output logic  stall_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o  <= ST_RUN;
         stall_o <= 1'b0;
      end else begin
         mode_o  <= plan_i.mode_nxt;
         stall_o <= plan_i.stall_nxt;
      end
   end
endmodule

// File: rtl/recov_seq_ctrl.sv
module recov_seq_ctrl
   import rsc_pkg::*;
#(
   parameter int ISSUES    = 4,
   parameter int ANY_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_fault_i,
   input  logic              old_src_i,
   input  logic [ISSUES-1:0] xsh_pend_i,
   input  logic [ISSUES-1:0] lsh_pend_i,
   input  logic [ISSUES-1:0] dec_dep_i,
   output logic              src_sel_o,
   output logic [1:0]        pass0_src_o,
   output logic [1:0]        pass1_src_o,
   output logic              cap_left_o,
   output logic              cap_exec_o,
   output logic              stall_o
);
   localparam int LANES = ISSUES;

   generate
      if (ISSUES < 1 || ISSUES > 32) begin : g_bad_issues
         $error("recov_seq_ctrl: ISSUES must be within 1..32");
      end
      if (ANY_STYLE != 0 && ANY_STYLE != 1) begin : g_bad_style
         $error("recov_seq_ctrl: ANY_STYLE must be 0 or 1");
      end
   endgenerate

   logic  x_any, l_any, d_any;
   plan_t plan;
   mode_e mode_q;

   rsc_any #(.WIDTH(LANES), .STYLE(ANY_STYLE)) u_any_x (.vec_i(xsh_pend_i), .any_o(x_any));
   rsc_any #(.WIDTH(LANES), .STYLE(ANY_STYLE)) u_any_l (.vec_i(lsh_pend_i), .any_o(l_any));
   rsc_any #(.WIDTH(LANES), .STYLE(ANY_STYLE)) u_any_d (.vec_i(dec_dep_i),  .any_o(d_any));

   rsc_plan u_plan (
      .mode_i   (mode_q),
      .fault_i  (new_fault_i),
      .old_src_i(old_src_i),
      .x_any_i  (x_any),
      .l_any_i  (l_any),
      .d_any_i  (d_any),
      .plan_o   (plan)
   );

   rsc_state u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .plan_i (plan),
      .mode_o (mode_q),
      .stall_o(stall_o)
   );

   assign src_sel_o   = plan.sel_exec;
   assign pass0_src_o = plan.first;
   assign pass1_src_o = plan.second;
   assign cap_exec_o  = 1'b1;
   assign cap_left_o  = ~stall_o;

   AST_FAST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      new_fault_i && !old_src_i |=> !stall_o); // R2
   AST_SLOW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      new_fault_i && old_src_i |=> stall_o); // R3
   AST_FAULT_EXEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      new_fault_i |-> src_sel_o && pass0_src_o == 2'd1); // R9
   AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == ST_REPLAY && !new_fault_i && x_any |=> stall_o && mode_q == ST_REPLAY); // R4
   AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !new_fault_i && mode_q == ST_RUN && !l_any && !d_any |=> !stall_o); // R7
   AST_LEFT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> !cap_left_o); // R8
endmodule

// File: tb/recov_seq_ctrl_tb.sv
`timescale 1ns/1ps
module recov_seq_ctrl_tb;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic new_fault, old_src;
   logic [N-1:0] xp, lp, dd;
   logic src_sel, cap_left, cap_exec, stall;
   logic [1:0] p0, p1;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct {
      logic [1:0] p0;
      logic [1:0] p1;
      logic       sel;
      logic       stall;
      string      req;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   recov_seq_ctrl #(.ISSUES(N), .ANY_STYLE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .new_fault_i(new_fault), .old_src_i(old_src),
      .xsh_pend_i(xp), .lsh_pend_i(lp), .dec_dep_i(dd),
      .src_sel_o(src_sel), .pass0_src_o(p0), .pass1_src_o(p1),
      .cap_left_o(cap_left), .cap_exec_o(cap_exec), .stall_o(stall)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the expected outputs
   task automatic step(input logic f, input logic o, input logic [N-1:0] x,
                       input logic [N-1:0] l, input logic [N-1:0] d,
                       input logic [1:0] e0, input logic [1:0] e1,
                       input logic es, input logic est, input string req);
      exp_t e;
      @(negedge clk);
      new_fault = f; old_src = o; xp = x; lp = l; dd = d;
      e.p0 = e0; e.p1 = e1; e.sel = es; e.stall = est; e.req = req;
      q.push_back(e);
   endtask

   // monitor: compare after inputs settle, well away from the rising edge
   always @(negedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.req, "pass0", int'(p0), int'(e.p0));
         chk(e.req, "pass1", int'(p1), int'(e.p1));
         chk(e.req, "sel",   int'(src_sel), int'(e.sel));
         chk(e.req, "stall", int'(stall), int'(e.stall));
         chk("R8", "cap_left", int'(cap_left), int'(!e.stall));
         chk("R8", "cap_exec", int'(cap_exec), 1);
      end
   end

   initial begin
      new_fault = 0; old_src = 0; xp = '0; lp = '0; dd = '0;
      repeat (3) @(negedge clk);
      chk("R1", "stall_in_reset", int'(stall), 0);
      rst_n = 1'b1;
      // codes: 0 none, 1 executed shadow, 2 leftover, 3 decoded
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,0, "R1");
      step(0,0,4'h0,4'h0,4'h1, 2,3,0,0, "R6");   // dependency seen
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,1, "R7");   // one stall cycle
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,0, "R7");   // released
      step(0,0,4'h0,4'h8,4'h0, 2,3,0,0, "R6");   // leftover pending
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,1, "R7");
      step(1,0,4'h3,4'h0,4'h0, 1,3,1,0, "R2");   // merge recovery
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,0, "R2");   // no stall after it
      step(1,1,4'h4,4'h0,4'h0, 1,0,1,0, "R3");   // replay recovery
      step(0,0,4'h4,4'h0,4'h0, 1,0,1,1, "R4");   // still pending
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,1, "R5");   // replay ends
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,0, "R5");
      step(1,1,4'h1,4'h0,4'h0, 1,0,1,0, "R3");
      step(0,0,4'h1,4'h0,4'h0, 1,0,1,1, "R4");
      step(1,0,4'h1,4'h0,4'h0, 1,3,1,1, "R9");   // fault pre-empts replay
      step(0,0,4'h2,4'h0,4'h0, 2,3,0,0, "R9");   // back in normal mode
      step(1,1,4'h2,4'h0,4'h0, 1,0,1,0, "R3");
      step(1,1,4'h2,4'h0,4'h0, 1,0,1,1, "R9");   // repeated slow fault
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,1, "R5");
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,0, "R5");
      step(0,0,4'h0,4'h0,4'h0, 2,3,0,0, "R1");
      @(negedge clk); #4;
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (2000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule